// File: doc/BRIEF.md
# TDM Serial Stream Receiver with Programmable Sampling Phase

This block turns one 32.768 Mbit/s time-division-multiplexed serial input into a sequence of 8-bit channel bytes. It runs on an internal clock at four times the bit rate, so every bit lasts four clock ticks. A two-bit setting chooses the tick on which the input is sampled: the middle, three-quarter or end point of each bit. This lets the sampling instant be moved to suit the jitter and the data delay seen on the line.

A one-cycle frame strobe marks the start of each frame. The strobe clears the tick, bit and channel counters and captures the sampling setting and the bit-order bit for the frame that follows. There are 512 channels in a frame. In one frame style a channel arrives most-significant bit first. In the other style it arrives least-significant bit first. Each time a channel's eighth bit has been sampled, the block presents the assembled byte and its channel index for one cycle, marked by a valid strobe.

Top module: `tdm_stream_rx`

## Requirements
- R1: While `rst_n` is low and afterwards, `byte_out` and `chan_out` read zero and `byte_valid` stays low until the first frame strobe after reset; serial activity without a strobe produces no byte.
- R2: In the cycle after a clock edge that samples `frame_sync` high, the block is at tick 0 of bit 0 of channel 0, and `byte_valid` is low in that cycle.
- R3: The ticks of a bit are numbered 0 to 3 from its start. `sample_sel` = 00 samples on tick 1 (1/2 point), 01 on tick 2 (3/4 point), 10 on tick 3 (4/4 point).
- R4: `sample_sel` = 11 is reserved and samples on tick 2, the same as 01.
- R5: With `lsb_first` = 0 the first bit of a channel lands in `byte_out[7]` and the last in `byte_out[0]`. With `lsb_first` = 1 the first bit lands in `byte_out[0]` and the last in `byte_out[7]`.
- R6: `byte_valid` is high for exactly one cycle, the cycle after the edge that samples a channel's eighth bit, with `byte_out` and `chan_out` holding that channel. At all other times it is low.
- R7: `chan_out` counts 0 to 511 through a frame. If no strobe arrives, the channel after 511 is channel 0.
- R8: `sample_sel` and `lsb_first` are captured only on the edge that samples `frame_sync` high. Changing them at any other time has no effect until the next strobe.
- R9: A frame strobe in the middle of a channel discards the partly assembled byte; no byte is reported for that channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, four ticks per bit |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | One-cycle frame-boundary strobe |
| ser_in | input | 1 | Serial TDM data |
| sample_sel | input | 2 | Sampling point code (00 half, 01 three-quarter, 10 end, 11 as 01) |
| lsb_first | input | 1 | Bit order: 0 most-significant first, 1 least-significant first |
| byte_out | output | 8 | Assembled channel byte |
| chan_out | output | 9 | Channel index of `byte_out` |
| byte_valid | output | 1 | One-cycle strobe marking a new byte |

## Verification
The bench drives a different pseudo-random level on each tick of every bit. A design that samples on the wrong tick, or that treats the reserved code as something other than the three-quarter point, therefore assembles wrong bytes. The bench swaps the sampling code and the bit order right after each strobe, so a design that follows these inputs mid-frame fails. It also runs one frame past channel 511 to catch a channel counter that saturates or mis-wraps. Strobes that land mid-channel, and data sent before the first strobe, expose designs that report stale partial bytes or start without a frame boundary.

// File: rtl/tdm_stream_rx.sv
module tdm_stream_rx #(
  parameter int TICKS    = 4,
  parameter int CH_BITS  = 8,
  parameter int CHANNELS = 512,
  localparam int TW = $clog2(TICKS),
  localparam int BW = $clog2(CH_BITS),
  localparam int CW = $clog2(CHANNELS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_sync,
  input  logic               ser_in,
  input  logic [1:0]         sample_sel,
  input  logic               lsb_first,
  output logic [CH_BITS-1:0] byte_out,
  output logic [CW-1:0]      chan_out,
  output logic               byte_valid
);

  localparam logic [TW-1:0] TICK_LAST = TW'(TICKS - 1);
  localparam logic [BW-1:0] BIT_LAST  = BW'(CH_BITS - 1);
  localparam logic [CW-1:0] CH_LAST   = CW'(CHANNELS - 1);
  localparam logic [TW-1:0] TICK_HALF = TW'(TICKS / 2 - 1);
  localparam logic [TW-1:0] TICK_3Q   = TW'((3 * TICKS) / 4 - 1);

  logic               running;
  logic [1:0]         act_sel;
  logic               act_lsb;
  logic [TW-1:0]      tick_cnt;
  logic [BW-1:0]      bit_cnt;
  logic [CW-1:0]      ch_cnt;
  logic [CH_BITS-1:0] shreg;
  logic [TW-1:0]      samp_tick;
  logic               samp_now;
  logic               last_bit;
  logic [CH_BITS-1:0] shreg_next;

  always_comb begin
    case (act_sel)
      2'b00:   samp_tick = TICK_HALF;
      2'b10:   samp_tick = TICK_LAST;
      default: samp_tick = TICK_3Q;
    endcase
  end

  assign samp_now   = running && (tick_cnt == samp_tick);
  assign last_bit   = samp_now && (bit_cnt == BIT_LAST);
  assign shreg_next = act_lsb ? {ser_in, shreg[CH_BITS-1:1]}
                              : {shreg[CH_BITS-2:0], ser_in};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      act_sel  <= 2'b01;
      act_lsb  <= 1'b0;
      tick_cnt <= '0;
      bit_cnt  <= '0;
      ch_cnt   <= '0;
    end else if (frame_sync) begin
      running  <= 1'b1;
      act_sel  <= sample_sel;
      act_lsb  <= lsb_first;
      tick_cnt <= '0;
      bit_cnt  <= '0;
      ch_cnt   <= '0;
    end else if (running) begin
      if (tick_cnt == TICK_LAST) begin
        tick_cnt <= '0;
        if (bit_cnt == BIT_LAST) begin
          bit_cnt <= '0;
          ch_cnt  <= (ch_cnt == CH_LAST) ? '0 : ch_cnt + 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end else begin
        tick_cnt <= tick_cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shreg      <= '0;
      byte_out   <= '0;
      chan_out   <= '0;
      byte_valid <= 1'b0;
    end else if (frame_sync) begin
      shreg      <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= last_bit;
      if (samp_now) shreg <= shreg_next;
      if (last_bit) begin
        byte_out <= shreg_next;
        chan_out <= ch_cnt;
      end
    end
  end

  assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  assert_sync_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> !byte_valid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !frame_sync) |=> !byte_valid);

  assert_settings_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> ($stable(act_sel) && $stable(act_lsb)));

  assert_sync_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (tick_cnt == '0 && bit_cnt == '0 && ch_cnt == '0 && running));

endmodule

// File: tb/tdm_stream_rx_bench.sv
module tdm_stream_rx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_sync = 1'b0;
  logic       ser_in = 1'b0;
  logic [1:0] sample_sel = 2'b01;
  logic       lsb_first = 1'b0;
  logic [7:0] byte_out;
  logic [8:0] chan_out;
  logic       byte_valid;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tdm_stream_rx u_tdm_stream_rx (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync), .ser_in(ser_in),
    .sample_sel(sample_sel), .lsb_first(lsb_first),
    .byte_out(byte_out), .chan_out(chan_out), .byte_valid(byte_valid)
  );

  function automatic bit pat(int ch, int b, int t, int seed);
    int v;
    v = ch * 37 + b * 11 + t * 53 + seed * 7 + (ch >> 3);
    return ^v[7:0];
  endfunction

  function automatic int samp_tick(int sel);
    case (sel)
      0: return 1;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(int ch, int sel, bit lsb, int seed);
    logic [7:0] r;
    int k;
    k = samp_tick(sel);
    r = '0;
    for (int b = 0; b < 8; b++) begin
      if (lsb) r[b] = pat(ch, b, k, seed);
      else     r[7 - b] = pat(ch, b, k, seed);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Frame strobe, then ncyc cycles of patterned data; settings flipped after strobe (R8)
  task automatic run_frame(int sel, bit lsb, int ncyc, int seed);
    int k;
    @(negedge clk);
    sample_sel = 2'(sel);
    lsb_first  = lsb;
    frame_sync = 1'b1;
    ser_in     = 1'b0;
    @(negedge clk);
    frame_sync = 1'b0;
    sample_sel = 2'((sel + 1) % 3);
    lsb_first  = ~lsb;
    check(byte_valid == 1'b0, "R2 valid after strobe", byte_valid, 0);
    k = samp_tick(sel);
    for (int q = 0; q < ncyc; q++) begin
      int t, b, ch;
      t  = q % 4;
      b  = (q / 4) % 8;
      ch = (q / 32) % 512;
      ser_in = pat(ch, b, t, seed);
      @(negedge clk);
      if (t == k && b == 7) begin
        check(byte_valid == 1'b1, "R6 valid strobe", byte_valid, 1);
        check(byte_out == exp_byte(ch, sel, lsb, seed),
              (sel == 3) ? "R4 reserved code byte" : (lsb ? "R5/R3 lsb-first byte" : "R3/R5 msb-first byte"),
              byte_out, exp_byte(ch, sel, lsb, seed));
        check(chan_out == 9'(ch), (q >= 512 * 32) ? "R7 channel wrap" : "R7 channel index", chan_out, ch);
      end else begin
        check(byte_valid == 1'b0, "R6 valid low between bytes", byte_valid, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(byte_valid == 1'b0, "R1 reset valid", byte_valid, 0);
    check(byte_out == 8'd0, "R1 reset byte", byte_out, 0);
    check(chan_out == 9'd0, "R1 reset channel", chan_out, 0);
    rst_n = 1'b1;
    // R1: data without a frame strobe yields nothing
    for (int i = 0; i < 100; i++) begin
      ser_in = pat(i, i, i, 5);
      @(negedge clk);
      check(byte_valid == 1'b0, "R1 no byte before strobe", byte_valid, 0);
    end
    // R3 R4 R5 R8: all codes and both orders
    for (int s = 0; s < 4; s++) begin
      for (int l = 0; l < 2; l++) begin
        run_frame(s, l[0], 20 * 32, s * 2 + l);
      end
    end
    // R9: strobes in mid-channel
    run_frame(0, 1'b0, 6 * 32 + 13, 21);
    run_frame(2, 1'b1, 3 * 32 + 30, 22);
    run_frame(1, 1'b0, 4 * 32 + 29, 23);
    run_frame(3, 1'b1, 5 * 32, 24);
    // R7: run past channel 511 without a strobe
    run_frame(1, 1'b1, 514 * 32, 30);
    // R1: reset mid-frame clears outputs and stops reception
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(byte_valid == 1'b0, "R1 reset valid again", byte_valid, 0);
    check(byte_out == 8'd0, "R1 reset byte again", byte_out, 0);
    check(chan_out == 9'd0, "R1 reset channel again", chan_out, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 80; i++) begin
      ser_in = pat(i, 3, i, 9);
      @(negedge clk);
      check(byte_valid == 1'b0, "R1 idle after reset", byte_valid, 0);
    end
    run_frame(2, 1'b0, 8 * 32, 40);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule